// File: doc/BRIEF.md
# Global Control Register Bank

This block is the global control register window of a board-level peripheral. It sits on a 32-bit bus with byte addresses and is accessed one word at a time. A host uses it to identify the logic: the format code, the letter revision, the product number, the build number and the system clock frequency. It also reads a table of function-block descriptors, which gives each block an ID, a register offset and a DMA offset. All of these contents are fixed when the block is built, through parameters. The table is computed from base values and strides.

There are two writable bytes in the first word. The highest byte is a reset command. Only the key value 0xAA starts a board reset pulse of fixed length. The next byte is an interrupt acknowledge, and only the value 0x01 counts. The block merges the interrupt status bits and the DMA interrupt status bits into a single interrupt request. A mode input selects one of two ways to deliver it: as a level on a line, or as a one-cycle message strobe that stands in for a message-signalled interrupt. If anything is still pending when the acknowledge arrives, the interrupt is delivered again. On the line this appears as a short low gap; in message mode it is a fresh strobe.

Top module: `gctl_regbank`

## Requirements
- R1: A write to word 0x00 with byte lane 3 enabled and data[31:24] = 0xAA drives `board_rst_o` high from the next clock edge for exactly RST_CYCLES (default 16) cycles. While the pulse runs, byte 3 of word 0x00 reads 0xAA. Once the pulse ends, byte 3 reads 0x00.
- R2: A write to byte 3 of word 0x00 has no effect on `board_rst_o` in either of these cases: the data byte is not 0xAA, or byte lane 3 is disabled.
- R3: Word 0x00 reads the format code 0x01 in bits [7:0], the revision in bits [15:8] (A=1, B=2, ...) and 0x00 in bits [23:16]. Word 0x04 reads the product number, word 0x08 the build number and word 0x0C the system clock frequency.
- R4: Word 0x10 reads the interrupt status inputs and word 0x18 reads the DMA interrupt status inputs. Both are zero-extended and both reflect the inputs at the read cycle.
- R5: For n = 0..FB_COUNT-1 the block has four words starting at 0x20+0x10*n. They hold, in this order, the ID FB_ID_BASE+n, the register offset FB_REG_BASE+n*FB_REG_STRIDE, the DMA offset FB_DMA_BASE+n*FB_DMA_STRIDE, and a reserved word that reads zero.
- R6: The following all read zero: reserved words, words past the table, and any address whose bits [1:0] are not 00. Writes to read-only words leave their contents unchanged.
- R7: A status bit that becomes pending while no interrupt is outstanding is delivered on the next clock edge. In legacy mode `irq_level_o` rises. In message mode `irq_msg_o` pulses for one cycle.
- R8: This case covers legacy mode with an interrupt outstanding and status still pending. A write of 0x01 to byte 2 of word 0x00 drops `irq_level_o` for exactly GAP_CYCLES (default 2) cycles. The line then rises again.
- R9: This case covers message mode with an interrupt outstanding and status still pending. The acknowledge write produces a new `irq_msg_o` pulse one cycle long on the next edge.
- R10: An acknowledge with nothing pending clears the outstanding interrupt, so `irq_level_o` falls. A byte-2 write of any value other than 0x01 is ignored.
- R11: While `msg_mode_i` is high, `irq_level_o` stays low.
- R12: Read data appears on `rdata_o` one cycle after the read request. In every cycle with no read request, `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write request |
| rd_en_i | input | 1 | Read request |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| wbe_i | input | 4 | Write byte enables |
| rdata_o | output | 32 | Registered read data |
| irq_status_i | input | IRQ_W | Interrupt status bits |
| dma_status_i | input | DMA_W | DMA interrupt status bits |
| msg_mode_i | input | 1 | 1 = message delivery, 0 = legacy level |
| irq_level_o | output | 1 | Legacy interrupt line |
| irq_msg_o | output | 1 | One-cycle interrupt message strobe |
| board_rst_o | output | 1 | Board reset pulse |

## Verification
The hardest situation to reach from the ports is a re-delivery, because the acknowledge must land while an interrupt is outstanding and a status bit is still held. The stimulus therefore raises a status bit and waits for delivery. It then writes the acknowledge while the bit is still set, and in legacy mode it watches the line fall for exactly the gap and rise again. The same sequence runs in message mode, where the acknowledge must produce a second strobe. Afterwards the status is cleared before a final acknowledge, to show the outstanding state clears.

// File: rtl/gctl_pkg.sv
package gctl_pkg;

    localparam logic [7:0] FMT_CODE = 8'h01;
    localparam logic [7:0] RST_KEY  = 8'hAA;
    localparam logic [7:0] ACK_KEY  = 8'h01;

    // word indices (byte address / 4)
    localparam int W_CTRL  = 0;
    localparam int W_PROD  = 1;
    localparam int W_BUILD = 2;
    localparam int W_CLK   = 3;
    localparam int W_IRQ   = 4;
    localparam int W_DMA   = 6;
    localparam int W_TBL   = 8;
    localparam int TBL_WORDS_PER_ENTRY = 4;

    typedef enum logic [1:0] {
        IRQ_IDLE   = 2'd0,
        IRQ_ACTIVE = 2'd1,
        IRQ_GAP    = 2'd2
    } irq_state_e;

    typedef struct packed {
        logic rst_cmd;
        logic ack_cmd;
    } ctrl_cmd_t;

    typedef struct packed {
        logic [7:0] rst_b;
        logic [7:0] ack_b;
        logic [7:0] rev_b;
        logic [7:0] fmt_b;
    } ctrl_word_t;

    function automatic logic [31:0] tbl_word(
        input int unsigned ent,
        input int unsigned sel,
        input logic [31:0] id_base,
        input logic [31:0] reg_base,
        input logic [31:0] reg_stride,
        input logic [31:0] dma_base,
        input logic [31:0] dma_stride
    );
        logic [31:0] r;
        case (sel)
            0:       r = id_base + 32'(ent);
            1:       r = reg_base + 32'(ent) * reg_stride;
            2:       r = dma_base + 32'(ent) * dma_stride;
            default: r = 32'h0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gctl_wr_decode.sv
module gctl_wr_decode
    import gctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [3:0]        wbe_i,
    output ctrl_cmd_t         cmd_o
);
    logic hit_ctrl;

    always_comb begin
        hit_ctrl       = wr_en_i && (addr_i == '0);
        cmd_o.rst_cmd  = hit_ctrl && wbe_i[3] && (wdata_i[31:24] == RST_KEY);
        cmd_o.ack_cmd  = hit_ctrl && wbe_i[2] && (wdata_i[23:16] == ACK_KEY);
    end

    // lanes 0 and 1 address read-only bytes: enables and data are not used
    logic unused_lanes;
    assign unused_lanes = ^{wbe_i[1:0], wdata_i[15:0]};

endmodule

// File: rtl/gctl_rd_mux.sv
module gctl_rd_mux
    import gctl_pkg::*;
#(
    parameter int          ADDR_W        = 8,
    parameter int          IRQ_W         = 16,
    parameter int          DMA_W         = 16,
    parameter int          FB_COUNT      = 9,
    parameter logic [7:0]  REV           = 8'h01,
    parameter logic [31:0] PRODUCT       = 32'h0,
    parameter logic [31:0] BUILD         = 32'h0,
    parameter logic [31:0] SYS_CLK_HZ    = 32'h0,
    parameter logic [31:0] FB_ID_BASE    = 32'h0,
    parameter logic [31:0] FB_REG_BASE   = 32'h0,
    parameter logic [31:0] FB_REG_STRIDE = 32'h0,
    parameter logic [31:0] FB_DMA_BASE   = 32'h0,
    parameter logic [31:0] FB_DMA_STRIDE = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rst_active_i,
    input  logic [IRQ_W-1:0]  irq_status_i,
    input  logic [DMA_W-1:0]  dma_status_i,
    output logic [31:0]       rdata_o
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int TBL_N  = FB_COUNT * TBL_WORDS_PER_ENTRY;

    logic [31:0] tbl [TBL_N];

    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
        assign tbl[g] = tbl_word(g / TBL_WORDS_PER_ENTRY, g % TBL_WORDS_PER_ENTRY,
                                 FB_ID_BASE, FB_REG_BASE, FB_REG_STRIDE,
                                 FB_DMA_BASE, FB_DMA_STRIDE);
    end

    logic [WORD_W-1:0] word;
    logic [31:0]       tbl_val;
    logic [31:0]       rd_val;
    ctrl_word_t        ctrl;

    assign word = addr_i[ADDR_W-1:2];

    always_comb begin
        tbl_val = 32'h0;
        for (int i = 0; i < TBL_N; i++) begin
            if (word == WORD_W'(W_TBL + i)) tbl_val = tbl[i];
        end
    end

    always_comb begin
        ctrl.rst_b = rst_active_i ? RST_KEY : 8'h00;
        ctrl.ack_b = 8'h00;
        ctrl.rev_b = REV;
        ctrl.fmt_b = FMT_CODE;
        if (addr_i[1:0] != 2'b00)              rd_val = 32'h0;
        else if (word == WORD_W'(W_CTRL))      rd_val = ctrl;
        else if (word == WORD_W'(W_PROD))      rd_val = PRODUCT;
        else if (word == WORD_W'(W_BUILD))     rd_val = BUILD;
        else if (word == WORD_W'(W_CLK))       rd_val = SYS_CLK_HZ;
        else if (word == WORD_W'(W_IRQ))       rd_val = 32'(irq_status_i);
        else if (word == WORD_W'(W_DMA))       rd_val = 32'(dma_status_i);
        else                                   rd_val = tbl_val;
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata_o <= 32'h0;
        else if (rd_en_i) rdata_o <= rd_val;
        else              rdata_o <= 32'h0;
    end

endmodule

// File: rtl/gctl_rst_pulse.sv
module gctl_rst_pulse #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic pulse_o
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (start_i)        cnt_q <= CW'(RST_CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign pulse_o = (cnt_q != '0);

endmodule

// File: rtl/gctl_irq_ctl.sv
module gctl_irq_ctl
    import gctl_pkg::*;
#(
    parameter int IRQ_W      = 16,
    parameter int DMA_W      = 16,
    parameter int GAP_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_i,
    input  logic             msg_mode_i,
    input  logic [IRQ_W-1:0] irq_status_i,
    input  logic [DMA_W-1:0] dma_status_i,
    output logic             level_o,
    output logic             msg_o
);
    localparam int          GW       = $clog2(GAP_CYCLES + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

    irq_state_e    st_q;
    logic [GW-1:0] gap_q;
    logic          pend;

    assign pend = (|irq_status_i) || (|dma_status_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= IRQ_IDLE;
            gap_q <= '0;
            msg_o <= 1'b0;
        end else begin
            msg_o <= 1'b0;
            case (st_q)
                IRQ_IDLE: begin
                    if (pend) begin
                        st_q  <= IRQ_ACTIVE;
                        msg_o <= msg_mode_i;
                    end
                end
                IRQ_ACTIVE: begin
                    if (ack_i) begin
                        if (!pend) begin
                            st_q <= IRQ_IDLE;
                        end else if (msg_mode_i) begin
                            msg_o <= 1'b1;
                        end else begin
                            st_q  <= IRQ_GAP;
                            gap_q <= '0;
                        end
                    end
                end
                IRQ_GAP: begin
                    if (gap_q == GAP_LAST) st_q <= pend ? IRQ_ACTIVE : IRQ_IDLE;
                    else                   gap_q <= gap_q + 1'b1;
                end
                default: st_q <= IRQ_IDLE;
            endcase
        end
    end

    assign level_o = (st_q == IRQ_ACTIVE) && !msg_mode_i;

endmodule

// File: rtl/gctl_regbank.sv
module gctl_regbank
    import gctl_pkg::*;
#(
    parameter int          ADDR_W        = 8,
    parameter int          IRQ_W         = 16,
    parameter int          DMA_W         = 16,
    parameter int          FB_COUNT      = 9,
    parameter int          RST_CYCLES    = 16,
    parameter int          GAP_CYCLES    = 2,
    parameter logic [7:0]  REV           = 8'h01,
    parameter logic [31:0] PRODUCT       = 32'h0000_1234,
    parameter logic [31:0] BUILD         = 32'h0000_0001,
    parameter logic [31:0] SYS_CLK_HZ    = 32'd100_000_000,
    parameter logic [31:0] FB_ID_BASE    = 32'h0001_0000,
    parameter logic [31:0] FB_REG_BASE   = 32'h0000_0100,
    parameter logic [31:0] FB_REG_STRIDE = 32'h0000_0100,
    parameter logic [31:0] FB_DMA_BASE   = 32'h0000_8000,
    parameter logic [31:0] FB_DMA_STRIDE = 32'h0000_0040
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [3:0]        wbe_i,
    output logic [31:0]       rdata_o,
    input  logic [IRQ_W-1:0]  irq_status_i,
    input  logic [DMA_W-1:0]  dma_status_i,
    input  logic              msg_mode_i,
    output logic              irq_level_o,
    output logic              irq_msg_o,
    output logic              board_rst_o
);
    ctrl_cmd_t cmd;

    gctl_wr_decode #(.ADDR_W(ADDR_W)) u_wr (
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .wbe_i   (wbe_i),
        .cmd_o   (cmd)
    );

    gctl_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk     (clk),
        .rst     (rst),
        .start_i (cmd.rst_cmd),
        .pulse_o (board_rst_o)
    );

    gctl_irq_ctl #(
        .IRQ_W      (IRQ_W),
        .DMA_W      (DMA_W),
        .GAP_CYCLES (GAP_CYCLES)
    ) u_irq (
        .clk          (clk),
        .rst          (rst),
        .ack_i        (cmd.ack_cmd),
        .msg_mode_i   (msg_mode_i),
        .irq_status_i (irq_status_i),
        .dma_status_i (dma_status_i),
        .level_o      (irq_level_o),
        .msg_o        (irq_msg_o)
    );

    gctl_rd_mux #(
        .ADDR_W        (ADDR_W),
        .IRQ_W         (IRQ_W),
        .DMA_W         (DMA_W),
        .FB_COUNT      (FB_COUNT),
        .REV           (REV),
        .PRODUCT       (PRODUCT),
        .BUILD         (BUILD),
        .SYS_CLK_HZ    (SYS_CLK_HZ),
        .FB_ID_BASE    (FB_ID_BASE),
        .FB_REG_BASE   (FB_REG_BASE),
        .FB_REG_STRIDE (FB_REG_STRIDE),
        .FB_DMA_BASE   (FB_DMA_BASE),
        .FB_DMA_STRIDE (FB_DMA_STRIDE)
    ) u_rd (
        .clk          (clk),
        .rst          (rst),
        .rd_en_i      (rd_en_i),
        .addr_i       (addr_i),
        .rst_active_i (board_rst_o),
        .irq_status_i (irq_status_i),
        .dma_status_i (dma_status_i),
        .rdata_o      (rdata_o)
    );

endmodule

// File: rtl/gctl_regbank_chk.sv
module gctl_regbank_chk #(
    parameter int ADDR_W     = 8,
    parameter int IRQ_W      = 16,
    parameter int DMA_W      = 16,
    parameter int RST_CYCLES = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [31:0]       wdata_i,
    input logic [3:0]        wbe_i,
    input logic [31:0]       rdata_o,
    input logic [IRQ_W-1:0]  irq_status_i,
    input logic [DMA_W-1:0]  dma_status_i,
    input logic              msg_mode_i,
    input logic              irq_level_o,
    input logic              irq_msg_o,
    input logic              board_rst_o
);
    logic [31:0] run_q;
    logic        ctrl_wr;
    logic        pend;

    assign ctrl_wr = wr_en_i && (addr_i == '0);
    assign pend    = (|irq_status_i) || (|dma_status_i);

    always_ff @(posedge clk) begin
        if (rst)              run_q <= 32'h0;
        else if (board_rst_o) run_q <= run_q + 32'h1;
        else                  run_q <= 32'h0;
    end

    p_rst_start_r1: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wbe_i[3] && wdata_i[31:24] == 8'hAA) |=> board_rst_o);

    p_rst_len_r1: assert property (@(posedge clk) disable iff (rst)
        ($fell(board_rst_o) && !$past(rst)) |-> (run_q >= 32'(RST_CYCLES)));

    p_rst_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        (!board_rst_o && ctrl_wr && (!wbe_i[3] || wdata_i[31:24] != 8'hAA)) |=> !board_rst_o);

    p_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wbe_i[2] && wdata_i[23:16] == 8'h01 && irq_level_o && pend && !msg_mode_i)
        |=> !irq_level_o);

    p_level_low_r11: assert property (@(posedge clk) disable iff (rst)
        msg_mode_i |-> !irq_level_o);

    p_msg_mode_r9: assert property (@(posedge clk) disable iff (rst)
        irq_msg_o |-> $past(msg_mode_i));

    p_rd_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> (rdata_o == 32'h0));

endmodule

bind gctl_regbank gctl_regbank_chk #(
    .ADDR_W     (ADDR_W),
    .IRQ_W      (IRQ_W),
    .DMA_W      (DMA_W),
    .RST_CYCLES (RST_CYCLES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .wbe_i        (wbe_i),
    .rdata_o      (rdata_o),
    .irq_status_i (irq_status_i),
    .dma_status_i (dma_status_i),
    .msg_mode_i   (msg_mode_i),
    .irq_level_o  (irq_level_o),
    .irq_msg_o    (irq_msg_o),
    .board_rst_o  (board_rst_o)
);

// File: tb/gctl_regbank_tb_top.sv
module gctl_regbank_tb_top;

    localparam int          ADDR_W   = 8;
    localparam int          IRQ_W    = 16;
    localparam int          DMA_W    = 16;
    localparam int          FB_COUNT = 9;
    localparam int          RSTC     = 16;
    localparam int          GAPC     = 2;
    localparam logic [7:0]  REV      = 8'h03;
    localparam logic [31:0] PROD     = 32'h0000_5A42;
    localparam logic [31:0] BLD      = 32'h2024_0917;
    localparam logic [31:0] CLKHZ    = 32'd125_000_000;
    localparam logic [31:0] IDB      = 32'h0040_0000;
    localparam logic [31:0] RGB      = 32'h0000_0200;
    localparam logic [31:0] RGS      = 32'h0000_0080;
    localparam logic [31:0] DMB      = 32'h0001_0000;
    localparam logic [31:0] DMS      = 32'h0000_0020;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wbe = '0;
    logic [31:0] rdata;
    logic [IRQ_W-1:0] irq_st = '0;
    logic [DMA_W-1:0] dma_st = '0;
    logic msg_mode = 1'b0;
    logic irq_level, irq_msg, board_rst;

    always #5 clk = ~clk;

    gctl_regbank #(
        .ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .DMA_W(DMA_W), .FB_COUNT(FB_COUNT),
        .RST_CYCLES(RSTC), .GAP_CYCLES(GAPC), .REV(REV), .PRODUCT(PROD),
        .BUILD(BLD), .SYS_CLK_HZ(CLKHZ), .FB_ID_BASE(IDB), .FB_REG_BASE(RGB),
        .FB_REG_STRIDE(RGS), .FB_DMA_BASE(DMB), .FB_DMA_STRIDE(DMS)
    ) dut_i (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
        .wdata_i(wdata), .wbe_i(wbe), .rdata_o(rdata), .irq_status_i(irq_st),
        .dma_status_i(dma_st), .msg_mode_i(msg_mode), .irq_level_o(irq_level),
        .irq_msg_o(irq_msg), .board_rst_o(board_rst)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // expected word contents, written from the requirements (R3..R6)
    function automatic logic [31:0] exp_word(input int a, input int rcnt);
        int n, w;
        if (a % 4 != 0) return 32'h0;
        if (a == 0)     return {(rcnt != 0) ? 8'hAA : 8'h00, 8'h00, REV, 8'h01};
        if (a == 4)     return PROD;
        if (a == 8)     return BLD;
        if (a == 12)    return CLKHZ;
        if (a == 16)    return 32'(irq_st);
        if (a == 24)    return 32'(dma_st);
        if (a >= 32 && a < 32 + 16 * FB_COUNT) begin
            n = (a - 32) / 16;
            w = (a % 16) / 4;
            if (w == 0) return IDB + 32'(n);
            if (w == 1) return RGB + 32'(n) * RGS;
            if (w == 2) return DMB + 32'(n) * DMS;
        end
        return 32'h0;
    endfunction

    // behavioural reference model, advanced at every rising edge
    int          m_rcnt = 0;
    int          m_state = 0;   // 0 none, 1 outstanding, 2 gap
    int          m_gap = 0;
    bit          m_msg = 0;
    logic [31:0] m_rdata = 0;
    bit          m_live = 0;

    always @(posedge clk) begin
        bit pend, ack, key;
        pend = (irq_st != 0) || (dma_st != 0);
        ack  = wr_en && addr == 0 && wbe[2] && wdata[23:16] == 8'h01;
        key  = wr_en && addr == 0 && wbe[3] && wdata[31:24] == 8'hAA;
        if (rst) begin
            m_rcnt = 0; m_state = 0; m_gap = 0; m_msg = 0; m_rdata = 0;
        end else begin
            m_rdata = rd_en ? exp_word(int'(addr), m_rcnt) : 32'h0;
            if (key)             m_rcnt = RSTC;
            else if (m_rcnt > 0) m_rcnt--;
            m_msg = 0;
            if (m_state == 0) begin
                if (pend) begin m_state = 1; m_msg = msg_mode; end
            end else if (m_state == 1) begin
                if (ack) begin
                    if (!pend)         m_state = 0;
                    else if (msg_mode) m_msg = 1;
                    else begin m_state = 2; m_gap = 0; end
                end
            end else begin
                if (m_gap == GAPC - 1) m_state = pend ? 1 : 0;
                else                   m_gap++;
            end
        end
        m_live = 1;
    end

    always @(negedge clk) begin
        if (m_live && !rst && !finished) begin
            check("R1 pulse model", {31'h0, board_rst}, {31'h0, m_rcnt != 0});
            check("R8 level model", {31'h0, irq_level}, {31'h0, m_state == 1 && !msg_mode});
            check("R9 msg model",   {31'h0, irq_msg},   {31'h0, m_msg});
            check("R12 rdata model", rdata, m_rdata);
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; wbe = be;
        @(negedge clk);
        wr_en = 1'b0; wbe = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state pulse", {31'h0, board_rst}, 32'h0);
        check("R7 reset state line", {31'h0, irq_level}, 32'h0);

        // identification and table (R3, R5, R6)
        bus_rd(8'h00, d); check("R3 word0", d, 32'h0000_0301);
        bus_rd(8'h04, d); check("R3 product", d, PROD);
        bus_rd(8'h08, d); check("R3 build", d, BLD);
        bus_rd(8'h0C, d); check("R3 clock", d, CLKHZ);
        bus_rd(8'h20, d); check("R5 id n0", d, IDB);
        bus_rd(8'h34, d); check("R5 reg off n1", d, RGB + RGS);
        bus_rd(8'hA8, d); check("R5 dma off n8", d, DMB + 32'd8 * DMS);
        bus_rd(8'hAC, d); check("R5 reserved n8", d, 32'h0);
        bus_rd(8'h14, d); check("R6 reserved", d, 32'h0);
        bus_rd(8'hB0, d); check("R6 past table", d, 32'h0);
        bus_rd(8'h06, d); check("R6 unaligned", d, 32'h0);
        bus_wr(8'h04, 32'hFFFF_FFFF, 4'hF);
        bus_rd(8'h04, d); check("R6 write to ro", d, PROD);
        bus_wr(8'h00, 32'h00FF_FFFF, 4'h3);
        bus_rd(8'h00, d); check("R6 ro bytes", d, 32'h0000_0301);
        @(negedge clk);
        check("R12 idle rdata", rdata, 32'h0);

        // reset command (R1, R2)
        bus_wr(8'h00, 32'h5500_0000, 4'h8);
        check("R2 wrong key", {31'h0, board_rst}, 32'h0);
        bus_wr(8'h00, 32'hAA00_0000, 4'h7);
        check("R2 lane off", {31'h0, board_rst}, 32'h0);
        bus_wr(8'h00, 32'hAA00_0000, 4'h8);
        hi = 0;
        while (board_rst && hi < 40) begin hi++; @(negedge clk); end
        check("R1 pulse length", 32'(hi), 32'(RSTC));
        bus_rd(8'h00, d); check("R1 byte after pulse", d, 32'h0000_0301);
        bus_wr(8'h00, 32'hAA00_0000, 4'h8);
        bus_rd(8'h00, d); check("R1 byte during pulse", d, 32'hAA00_0301);
        repeat (RSTC) @(negedge clk);

        // legacy interrupt (R4, R7, R8, R10)
        @(negedge clk); irq_st = 16'h0040;
        @(negedge clk); check("R7 legacy raise", {31'h0, irq_level}, 32'h1);
        bus_rd(8'h10, d); check("R4 irq status", d, 32'h0000_0040);
        bus_wr(8'h00, 32'h0002_0000, 4'h4);
        check("R10 bad ack ignored", {31'h0, irq_level}, 32'h1);
        bus_wr(8'h00, 32'h0001_0000, 4'h4);
        check("R8 gap cycle 1", {31'h0, irq_level}, 32'h0);
        @(negedge clk); check("R8 gap cycle 2", {31'h0, irq_level}, 32'h0);
        @(negedge clk); check("R8 reassert", {31'h0, irq_level}, 32'h1);
        irq_st = '0;
        bus_wr(8'h00, 32'h0001_0000, 4'h4);
        check("R10 ack clears", {31'h0, irq_level}, 32'h0);
        @(negedge clk); check("R10 stays clear", {31'h0, irq_level}, 32'h0);

        // message mode (R4, R7, R9, R11)
        msg_mode = 1'b1;
        @(negedge clk); dma_st = 16'h0101;
        @(negedge clk);
        check("R7 msg raise", {31'h0, irq_msg}, 32'h1);
        check("R11 line low", {31'h0, irq_level}, 32'h0);
        @(negedge clk); check("R9 strobe one cycle", {31'h0, irq_msg}, 32'h0);
        bus_rd(8'h18, d); check("R4 dma status", d, 32'h0000_0101);
        bus_wr(8'h00, 32'h0001_0000, 4'h4);
        check("R9 ack resends", {31'h0, irq_msg}, 32'h1);
        @(negedge clk); check("R9 resend one cycle", {31'h0, irq_msg}, 32'h0);
        dma_st = '0;
        bus_wr(8'h00, 32'h0001_0000, 4'h4);
        check("R10 msg ack none pending", {31'h0, irq_msg}, 32'h0);
        irq_st = 16'h8000;
        @(negedge clk); check("R7 msg new raise", {31'h0, irq_msg}, 32'h1);
        check("R11 line low again", {31'h0, irq_level}, 32'h0);
        irq_st = '0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule